// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Masked Interrupt

This block recovers characters from an asynchronous serial line, idle high, using a 16x oversampling tick that the surrounding logic supplies. Each character has a start bit, then 7 or 8 data bits sent least significant bit first. An optional extra bit may follow, which 9-bit address networks use. One stop bit completes the character. The data byte and the extra bit are written together into one entry of an 8-deep queue. A configuration input can shrink the queue to a single holding buffer.

A host reads the entry at the head with a one-cycle read strobe, which also removes it. The block keeps a sticky flag for stop-bit errors. While the block is in shutdown, the same flag records any activity on the line. Four status terms are each combined with a mask input. Their OR drives a registered active-low interrupt request. Generating the oversampling tick and the host-side register protocol are handled elsewhere.

Top module: `serial_rx_queue`

## Requirements
- R1: A start bit is accepted only if the line is still low 8 ticks after the first low seen at a tick. A shorter low pulse stores nothing. Every later bit is sampled 16 ticks after the previous one, and data arrives least significant bit first.
- R2: With `cfg_len7`=1 a character carries 7 data bits, and bit 7 of `rd_data` reads 0.
- R3: With `cfg_par_en`=1, the bit after the data bits is stored and shown on `rd_par`. With `cfg_par_en`=0, the stored extra bit is 0.
- R4: The queue holds up to DEPTH (8) entries and returns them in arrival order. A `rd` pulse removes the head.
- R5: A character that completes while the queue is full is dropped, and the stored entries are kept.
- R6: With `cfg_fifo_off`=1 only a single entry is held. A second character that arrives before the read is dropped.
- R7: A 0 sampled at the stop-bit position sets `err_act`, stores nothing, and returns the receiver to searching for a start bit. A `rd` pulse does not clear `err_act`. The next correctly framed character clears it, and so does a `cfg_wr` pulse.
- R8: `avail` is 1 exactly when the queue holds an entry. When it is 0, `rd_data` and `rd_par` read 0.
- R9: `irq_n` is registered. It goes low one cycle after any of these pairs is both 1: `avail` and `m_avail`, `tx_empty` and `m_txe`, `rd_par` and `m_par`, or `err_act` and `m_err`. It returns high one cycle after no pair holds.
- R10: While `sleep`=1 the queue is emptied, the receiver stays idle, and the `tx_empty` term is ignored. Entering `sleep` clears `err_act`.
- R11: While `sleep`=1, any transition on `rx` sets `err_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx | input | 1 | Serial line, idle high |
| cfg_fifo_off | input | 1 | 1: single buffer instead of queue |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | 1: extra bit after the data bits |
| cfg_wr | input | 1 | Configuration write pulse, clears `err_act` |
| sleep | input | 1 | Shutdown level |
| rd | input | 1 | Read strobe, removes the head entry |
| tx_empty | input | 1 | Transmitter-ready status from the sending side |
| m_avail | input | 1 | Interrupt mask for `avail` |
| m_txe | input | 1 | Interrupt mask for `tx_empty` |
| m_par | input | 1 | Interrupt mask for `rd_par` |
| m_err | input | 1 | Interrupt mask for `err_act` |
| rd_data | output | 8 | Head entry data |
| rd_par | output | 1 | Head entry extra bit |
| avail | output | 1 | Queue not empty |
| err_act | output | 1 | Framing error, or line activity while in shutdown |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Bad internal state shows up at the ports in one of a few ways:
- A wrong write or read pointer, or a wrong fill count, gives a data byte out of order, or a missing or extra character, at the very next read. That is why the queue is filled past capacity and then drained completely.
- A sampling point in the wrong place shifts or corrupts the data bits within one character. Early start confirmation turns a short glitch into a spurious entry.
- The error flag and the interrupt are visible on their own pins within one or two cycles of their cause. The bench samples them there, both before and after the events that are supposed to leave them unchanged.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx,
  input  logic       cfg_fifo_off,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_wr,
  input  logic       sleep,
  input  logic       rd,
  input  logic       tx_empty,
  input  logic       m_avail,
  input  logic       m_txe,
  input  logic       m_par,
  input  logic       m_err,
  output logic [7:0] rd_data,
  output logic       rd_par,
  output logic       avail,
  output logic       err_act,
  output logic       irq_n
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(OSR);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  logic [2:0]    rx_sync;
  logic          sleep_d;
  st_t           st;
  logic [TW-1:0] cnt;
  logic [3:0]    bidx;
  logic [8:0]    sh;
  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;

  wire rxs     = rx_sync[1];
  wire rx_edge = rx_sync[2] ^ rx_sync[1];
  wire at_mid  = tick16 && (cnt == TW'(OSR/2 - 1));
  wire at_bit  = tick16 && (cnt == TW'(OSR - 1));
  wire [3:0] nbits = (cfg_len7 ? 4'd7 : 4'd8) + {3'd0, cfg_par_en};
  wire good = (st == S_STOP) && at_bit && rxs;
  wire bad  = (st == S_STOP) && at_bit && !rxs;

  wire       par_in = cfg_par_en && (cfg_len7 ? sh[7] : sh[8]);
  wire [8:0] wdata  = {par_in, cfg_len7 ? {1'b0, sh[6:0]} : sh[7:0]};

  wire [CW-1:0] cap = cfg_fifo_off ? CW'(1) : CW'(DEPTH);
  wire push = good && (fill < cap);
  wire pop  = rd && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= 3'b111;
      sleep_d <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[1:0], rx};
      sleep_d <= sleep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
    end else if (tick16) begin
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE:
          if (!rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (at_mid) begin
            st   <= rxs ? S_IDLE : S_BITS;
            cnt  <= '0;
            bidx <= '0;
          end
        S_BITS:
          if (at_bit) begin
            sh[bidx] <= rxs;
            bidx     <= bidx + 1'b1;
            if (bidx == nbits - 1'b1) st <= S_STOP;
          end
        S_STOP:
          if (at_bit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign avail   = (fill != '0);
  assign rd_data = avail ? mem[rp][7:0] : 8'h00;
  assign rd_par  = avail && mem[rp][8];

  always_ff @(posedge clk) begin
    if (!rst_n) err_act <= 1'b0;
    else if (sleep) begin
      if (!sleep_d)     err_act <= 1'b0;
      else if (rx_edge) err_act <= 1'b1;
    end else if (bad)            err_act <= 1'b1;
    else if (good || cfg_wr)     err_act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n <= 1'b1;
    else irq_n <= !((avail && m_avail) || (tx_empty && !sleep && m_txe) ||
                    (rd_par && m_par) || (err_act && m_err));
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R6
  bypass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_off && $past(cfg_fifo_off) && ($past(fill) <= 1)) |-> (fill <= 1));
  // R8
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |-> (rd_data == 8'h00 && !rd_par));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(m_avail || m_txe || m_par || m_err)) |-> irq_n);
  // R10
  sleep_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !avail);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_act) && $past(rd) && !$past(sleep) && !$past(cfg_wr) && !$past(good)) |-> err_act);
endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;
  logic clk = 0, rst_n = 0, tick16 = 0, rx = 1;
  logic cfg_fifo_off = 0, cfg_len7 = 0, cfg_par_en = 0, cfg_wr = 0, sleep = 0, rd = 0;
  logic tx_empty = 0, m_avail = 0, m_txe = 0, m_par = 0, m_err = 0;
  logic [7:0] rd_data;
  logic rd_par, avail, err_act, irq_n;
  int checks = 0, fails = 0;
  logic [1:0] div = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div    <= div + 1'b1;
    tick16 <= (div == 2'd3);
  end

  serial_rx_queue u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic b);
    rx = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input int n, input logic stopb);
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < n; i++) bit_time(v[i]);
    bit_time(stopb);
    rx = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic pulse_rd;
    @(negedge clk); rd = 1; @(negedge clk); rd = 0; @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input logic [7:0] d, input logic p);
    chk(req, {15'd0, avail}, 16'd1);
    chk(req, {8'd0, rd_data}, {8'd0, d});
    chk(req, {15'd0, rd_par}, {15'd0, p});
    pulse_rd();
  endtask

  task automatic t_reset;
    chk("R8 reset avail", {15'd0, avail}, 16'd0);
    chk("R8 reset data", {8'd0, rd_data}, 16'd0);
    chk("R7 reset err", {15'd0, err_act}, 16'd0);
    chk("R9 reset irq", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_basic;
    send(9'h0A5, 8, 1'b1);
    expect_rd("R1 byte A5", 8'hA5, 1'b0);
    send(9'h05A, 8, 1'b1);
    expect_rd("R1 byte 5A", 8'h5A, 1'b0);
    chk("R8 empty after read", {15'd0, avail}, 16'd0);
  endtask

  task automatic t_glitch;
    @(negedge clk); rx = 0;
    repeat (16) @(negedge clk); rx = 1;
    repeat (200) @(negedge clk);
    chk("R1 glitch ignored", {15'd0, avail}, 16'd0);
  endtask

  task automatic t_len7;
    cfg_len7 = 1;
    send(9'h0FF, 7, 1'b1);
    expect_rd("R2 seven bit", 8'h7F, 1'b0);
    send(9'h055, 7, 1'b1);
    expect_rd("R2 seven bit 55", 8'h55, 1'b0);
    cfg_len7 = 0;
  endtask

  task automatic t_par;
    cfg_par_en = 1; m_par = 1;
    send(9'h13C, 9, 1'b1);
    chk("R9 par irq low", {15'd0, irq_n}, 16'd0);
    expect_rd("R3 extra bit 1", 8'h3C, 1'b1);
    @(negedge clk);
    chk("R9 par irq released", {15'd0, irq_n}, 16'd1);
    send(9'h0C3, 9, 1'b1);
    expect_rd("R3 extra bit 0", 8'hC3, 1'b0);
    cfg_par_en = 0;
    send(9'h03C, 8, 1'b1);
    expect_rd("R3 disabled", 8'h3C, 1'b0);
    m_par = 0;
  endtask

  task automatic t_fifo;
    for (int i = 0; i < 9; i++) send(9'(8'h10 + i), 8, 1'b1);
    for (int i = 0; i < 8; i++) expect_rd("R4 order", 8'(8'h10 + i), 1'b0);
    chk("R5 ninth dropped", {15'd0, avail}, 16'd0);
  endtask

  task automatic t_bypass;
    cfg_fifo_off = 1;
    send(9'h061, 8, 1'b1);
    send(9'h062, 8, 1'b1);
    expect_rd("R6 single buffer", 8'h61, 1'b0);
    chk("R6 second dropped", {15'd0, avail}, 16'd0);
    cfg_fifo_off = 0;
  endtask

  task automatic t_frame;
    send(9'h0AA, 8, 1'b0);
    chk("R7 err set", {15'd0, err_act}, 16'd1);
    chk("R7 nothing stored", {15'd0, avail}, 16'd0);
    pulse_rd();
    chk("R7 read keeps err", {15'd0, err_act}, 16'd1);
    send(9'h077, 8, 1'b1);
    chk("R7 good char clears", {15'd0, err_act}, 16'd0);
    expect_rd("R7 good char data", 8'h77, 1'b0);
    send(9'h0AA, 8, 1'b0);
    chk("R7 err set again", {15'd0, err_act}, 16'd1);
    @(negedge clk); cfg_wr = 1; @(negedge clk); cfg_wr = 0; @(negedge clk);
    chk("R7 cfg_wr clears", {15'd0, err_act}, 16'd0);
  endtask

  task automatic t_irq;
    send(9'h033, 8, 1'b1);
    chk("R9 unmasked high", {15'd0, irq_n}, 16'd1);
    @(negedge clk); m_avail = 1; repeat (2) @(negedge clk);
    chk("R9 avail irq", {15'd0, irq_n}, 16'd0);
    m_avail = 0; repeat (2) @(negedge clk);
    chk("R9 mask cleared", {15'd0, irq_n}, 16'd1);
    pulse_rd();
    tx_empty = 1; m_txe = 1; repeat (2) @(negedge clk);
    chk("R9 txe irq", {15'd0, irq_n}, 16'd0);
    tx_empty = 0; repeat (2) @(negedge clk);
    chk("R9 txe released", {15'd0, irq_n}, 16'd1);
    m_txe = 0;
  endtask

  task automatic t_sleep;
    send(9'h044, 8, 1'b1);
    send(9'h0AA, 8, 1'b0);
    chk("R10 pre avail", {15'd0, avail}, 16'd1);
    tx_empty = 1; m_txe = 1;
    @(negedge clk); sleep = 1; repeat (3) @(negedge clk);
    chk("R10 queue cleared", {15'd0, avail}, 16'd0);
    chk("R10 err cleared", {15'd0, err_act}, 16'd0);
    chk("R10 txe ignored", {15'd0, irq_n}, 16'd1);
    m_err = 1; rx = 0; repeat (4) @(negedge clk);
    chk("R11 activity", {15'd0, err_act}, 16'd1);
    chk("R11 activity irq", {15'd0, irq_n}, 16'd0);
    rx = 1; repeat (4) @(negedge clk);
    sleep = 0; m_err = 0; m_txe = 0; tx_empty = 0;
    @(negedge clk); cfg_wr = 1; @(negedge clk); cfg_wr = 0; repeat (3) @(negedge clk);
    chk("R7 cleared after sleep", {15'd0, err_act}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_len7();
    t_par();
    t_fifo();
    t_bypass();
    t_frame();
    t_irq();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule